// File: doc/BRIEF.md
# Two-Stage RTC Prescaler

This block divides the real-time-clock domain clock in two cascaded stages. The first stage is a down-counter reloaded from a 7-bit setting. It emits a one-cycle subsecond tick once every (setting + 1) clock cycles. The second stage is a 15-bit down-counter that moves only on subsecond ticks. When it wraps, it emits a one-cycle calendar tick, which feeds the calendar and the periodic wakeup logic. The calendar tick rate is the input rate divided by (A + 1) × (B + 1). With a 32.768 kHz clock, an A setting of 127 and a B setting of 255 give exactly one calendar tick per second.

The live value of the second-stage counter is driven out as the subsecond reading. A synchronous load strobe reloads both counters at once from the current settings, so a new division ratio starts from a clean phase. If a setting changes without a load, the new value is used only at that stage's next natural reload.

Top module: `rtc_prescaler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both ticks are low and the subsecond reading equals the B reset value (default 255). The first subsecond tick follows A reset value + 1 cycles after reset release (default 127 + 1).
- R2: The subsecond tick is a one-cycle pulse. It repeats every div_a + 1 cycles while no load occurs. With div_a nonzero it is never high in two consecutive cycles.
- R3: The calendar tick is high only in a cycle where the subsecond tick is high and the subsecond reading is 0. It repeats every (div_a + 1) × (div_b + 1) cycles.
- R4: The subsecond reading falls by exactly one after a subsecond tick that is not a calendar tick. It holds its value in cycles without a subsecond tick.
- R5: After a calendar tick, the subsecond reading equals the div_b value presented in the tick cycle.
- R6: In a cycle with load high, neither tick is asserted. In the following cycle, the subsecond reading equals the div_b value presented with the load, and the first stage restarts from div_a.
- R7: When load coincides with a cycle in which a tick would otherwise fire, the load takes priority: the tick is suppressed and both counters take the new settings.
- R8: A div_a of 0 gives a subsecond tick every cycle. A div_b of 0 makes every subsecond tick also a calendar tick.
- R9: With div_a = 127 and div_b = 255, calendar ticks are exactly 32768 cycles apart and subsecond ticks 128 cycles apart.
- R10: A change to div_a or div_b without a load does not disturb the running count. It takes effect at that stage's next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Synchronous reload of both stages from the settings |
| div_a_i | input | 7 | First-stage division setting (ratio = value + 1) |
| div_b_i | input | 15 | Second-stage division setting (ratio = value + 1) |
| tick_sub_o | output | 1 | One-cycle subsecond tick |
| tick_cal_o | output | 1 | One-cycle calendar / wakeup tick |
| subsec_o | output | 15 | Live second-stage count (subsecond reading) |

## Verification
Two events can fall in the same cycle: a natural wrap, which fires a tick and reloads a stage, and an explicit load strobe. The bench uses its own model to find a cycle in which both counters stand at zero, so that a calendar tick is due. It raises load in exactly that cycle. It then checks that neither tick appears and that the subsecond reading on the next cycle is the freshly presented div_b, not a wrapped or decremented value. A reference model compares every output on every cycle throughout the run.

// File: rtl/rtc_prescaler_pkg.sv
package rtc_prescaler_pkg;
   localparam int unsigned DEF_A_W   = 7;
   localparam int unsigned DEF_B_W   = 15;
   localparam int unsigned DEF_A_RST = 127;
   localparam int unsigned DEF_B_RST = 255;

   // cycles between calendar ticks for given settings
   function automatic longint unsigned cal_period(input longint unsigned a,
                                                  input longint unsigned b);
      return (a + 1) * (b + 1);
   endfunction
endpackage

// File: rtl/rtc_div_stage.sv
module rtc_div_stage #(
   parameter int unsigned W       = 7,
   parameter int unsigned RST_VAL = 127,
   parameter bit          GATED   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   input  logic         load_i,
   input  logic [W-1:0] reload_i,
   output logic         zero_o,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] RST_CNT = W'(RST_VAL);

   if (W < 1) begin : g_bad_w
      $error("rtc_div_stage: W must be at least 1");
   end
   if (RST_VAL >= (64'd1 << W)) begin : g_bad_rst
      $error("rtc_div_stage: RST_VAL does not fit in W bits");
   end

   logic         adv;
   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_d;

   // variant: a free-running stage ignores step_i
   if (GATED) begin : g_gated
      assign adv = step_i;
   end else begin : g_free
      logic unused_step;
      assign unused_step = step_i;
      assign adv = 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   always_comb begin
      cnt_d = cnt_q;
      if (load_i) begin
         cnt_d = reload_i;
      end else if (adv) begin
         cnt_d = zero_o ? reload_i : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= RST_CNT;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
   import rtc_prescaler_pkg::*;
#(
   parameter int unsigned WA    = DEF_A_W,
   parameter int unsigned WB    = DEF_B_W,
   parameter int unsigned A_RST = DEF_A_RST,
   parameter int unsigned B_RST = DEF_B_RST
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [WA-1:0] div_a_i,
   input  logic [WB-1:0] div_b_i,
   output logic          tick_sub_o,
   output logic          tick_cal_o,
   output logic [WB-1:0] subsec_o
);
   if (WA < 1 || WB < 1) begin : g_bad_w
      $error("rtc_prescaler: stage widths must be at least 1");
   end

   logic          zero_a;
   logic          zero_b;
   logic [WA-1:0] cnt_a;
   logic          tick_sub;
   logic          unused_a;

   rtc_div_stage #(.W(WA), .RST_VAL(A_RST), .GATED(1'b0)) u_stage_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (1'b1),
      .load_i   (load_i),
      .reload_i (div_a_i),
      .zero_o   (zero_a),
      .cnt_o    (cnt_a)
   );

   // load has priority over any natural wrap
   assign tick_sub = zero_a & ~load_i;

   rtc_div_stage #(.W(WB), .RST_VAL(B_RST), .GATED(1'b1)) u_stage_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (tick_sub),
      .load_i   (load_i),
      .reload_i (div_b_i),
      .zero_o   (zero_b),
      .cnt_o    (subsec_o)
   );

   assign unused_a   = ^cnt_a;
   assign tick_sub_o = tick_sub;
   assign tick_cal_o = tick_sub & zero_b;
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
   parameter int unsigned WA = 7,
   parameter int unsigned WB = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          load_i,
   input logic [WA-1:0] div_a_i,
   input logic [WB-1:0] div_b_i,
   input logic          tick_sub_o,
   input logic          tick_cal_o,
   input logic [WB-1:0] subsec_o
);
   AST_SUB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_sub_o && !load_i && div_a_i != '0) |=> !tick_sub_o); // R2
   AST_CAL_IN_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cal_o |-> (tick_sub_o && subsec_o == '0)); // R3
   AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_sub_o && !load_i) |=> $stable(subsec_o)); // R4
   AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_sub_o && !tick_cal_o) |=> (subsec_o == $past(subsec_o) - 1'b1)); // R4
   AST_CAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cal_o |=> (subsec_o == $past(div_b_i))); // R5
   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (!tick_sub_o && !tick_cal_o)); // R6
   AST_LOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (subsec_o == $past(div_b_i))); // R7
endmodule

bind rtc_prescaler rtc_prescaler_chk #(.WA(WA), .WB(WB)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .div_a_i    (div_a_i),
   .div_b_i    (div_b_i),
   .tick_sub_o (tick_sub_o),
   .tick_cal_o (tick_cal_o),
   .subsec_o   (subsec_o)
);

// File: tb/rtc_prescaler_tb_top.sv
module rtc_prescaler_tb_top;
   localparam int A_RST = 127;
   localparam int B_RST = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [6:0]  div_a = 7'd0;
   logic [14:0] div_b = 15'd0;
   logic        tick_sub;
   logic        tick_cal;
   logic [14:0] subsec;

   int checks = 0;
   int errors = 0;
   int ma = A_RST;
   int mb = B_RST;
   int gap_sub = 0, gap_cal = 0, per_sub = 0, per_cal = 0;
   longint cyc = 0;

   always #10 clk = ~clk;

   rtc_prescaler dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load), .div_a_i(div_a), .div_b_i(div_b),
      .tick_sub_o(tick_sub), .tick_cal_o(tick_cal), .subsec_o(subsec)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // reference model state advance
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         ma = A_RST; mb = B_RST;
      end else if (load) begin
         ma = int'(div_a); mb = int'(div_b);
      end else if (ma == 0) begin
         ma = int'(div_a);
         mb = (mb == 0) ? int'(div_b) : mb - 1;
      end else begin
         ma--;
      end
   end

   // every-cycle comparison and period measurement
   always @(negedge clk) begin
      bit es, ec;
      #3;
      es = rst_n && (ma == 0) && !load;
      ec = es && (mb == 0);
      chk("R2 tick_sub", tick_sub, es);
      chk("R3 tick_cal", tick_cal, ec);
      chk("R4 subsec", subsec, mb);
      #1;
      gap_sub++; gap_cal++;
      if (tick_sub) begin per_sub = gap_sub; gap_sub = 0; end
      if (tick_cal) begin per_cal = gap_cal; gap_cal = 0; end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_load(input int a, input int b);
      @(negedge clk);
      div_a = 7'(a); div_b = 15'(b); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int first;
      cycles(3);
      #5;
      chk("R1 reset tick_sub", tick_sub, 0);
      chk("R1 reset tick_cal", tick_cal, 0);
      chk("R1 reset subsec", subsec, B_RST);
      // release, count cycles to first subsecond tick
      @(negedge clk);
      rst_n = 1'b1;
      first = 0;
      for (int i = 0; i < 200; i++) begin
         #5;
         first++;
         if (tick_sub) break;
         @(negedge clk);
      end
      chk("R1 first tick latency", first, A_RST + 1);

      // small ratios
      do_load(3, 2);
      cycles(40);
      chk("R2 sub period", per_sub, 4);
      chk("R3 cal period", per_cal, 12);

      // change div_a without load
      @(negedge clk);
      div_a = 7'd5;
      cycles(60);
      chk("R10 sub period after change", per_sub, 6);
      chk("R10 cal period after change", per_cal, 18);

      // zero settings
      do_load(0, 0);
      cycles(4);
      #5;
      chk("R8 tick_sub every cycle", tick_sub, 1);
      chk("R8 tick_cal every cycle", tick_cal, 1);
      chk("R8 cal period", per_cal, 1);

      // load with new B value
      do_load(4, 9);
      #5;
      chk("R6 subsec after load", subsec, 9);
      chk("R5 sub tick after load", tick_sub, 0);
      cycles(120);
      chk("R5 cal period", per_cal, 50);

      // load collides with a due calendar tick
      do_load(2, 1);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         #1;
         if (ma == 0 && mb == 0) break;
      end
      div_b = 15'd7; div_a = 7'd3; load = 1'b1;
      #2;
      chk("R7 tick_cal suppressed", tick_cal, 0);
      chk("R7 tick_sub suppressed", tick_sub, 0);
      @(negedge clk);
      load = 1'b0;
      #5;
      chk("R7 subsec takes new div_b", subsec, 7);

      // one-second configuration
      do_load(127, 255);
      cycles(2 * 32768 + 20);
      chk("R9 cal period", per_cal, 32768);
      chk("R9 sub period", per_sub, 128);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule